// File: doc/BRIEF.md
# Reference clock switchover controller

This block picks which of two reference clocks feeds a downstream clock consumer. A free-running system clock runs the whole block. Both reference inputs go through synchronizers. A loss detector watches each reference and raises a per-input bad flag when that reference stops toggling. A switch controller then moves the selection to the other input. The controller follows one of three policies: automatic, manual, or automatic with a manual override.

The result leaves the block in two forms. The first is a select bit: 0 means the primary input, 1 means the secondary. The second is a pair of one-hot mux enables for a glitch-free clock mux. During every switch, both enables drop to zero for a programmable number of cycles. Only then does the enable for the new input come on.

The mode, the switch delay and the loss timeout are static configuration inputs. Recovering lock in any analog loop downstream is not part of this block.

Top module: `refclk_switch_ctrl`

## Requirements
- R1: After reset, active_sel is 0, clk_bad is 2'b00 and mux_en is 2'b01.
- R2: clk_bad[i] goes high after input i shows no synchronized rising edge for loss_limit system cycles. A loss_limit below 8 is treated as 8. The flag stays low while input i toggles at least once every 8 cycles.
- R3: A raised clk_bad[i] clears only after 4 rising edges of input i with no timeout between them. After 3 such edges it is still set.
- R4: In automatic mode (op_mode 0, and op_mode 3, which behaves the same), a bad flag on the selected input while the other input is good causes a switch to the other input.
- R5: An automatic switch never moves to an input whose bad flag is set. When both inputs are bad, the current selection is held.
- R6: In manual mode (op_mode 1), the selection toggles once when sw_req rises and stays high for at least 3 system cycles. A high pulse of 2 cycles is ignored. Holding sw_req high longer gives only one switch.
- R7: In manual mode, losing the selected clock does not change the selection.
- R8: In override mode (op_mode 2), sw_req switches as in R6. While sw_req stays high, automatic switching is blocked. Once sw_req falls, automatic switching resumes.
- R9: Each switch holds mux_en at 2'b00 for sw_delay+1 consecutive cycles, where sw_delay ranges from 0 to 7. After that, mux_en becomes one-hot for the new selection.
- R10: mux_en is never anything other than 2'b00, 2'b01 or 2'b10. It never moves directly from one input to the other. When it is non-zero, the bit it drives high is the one picked by active_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 2 | 0/3 automatic, 1 manual, 2 automatic with manual override |
| sw_req | input | 1 | Asynchronous manual switch request |
| sw_delay | input | DLY_W | Extra switch delay, in system cycles |
| loss_limit | input | TMO_W | Cycles without an edge before an input is declared bad |
| ref_clk0 | input | 1 | Primary reference clock |
| ref_clk1 | input | 1 | Secondary reference clock |
| active_sel | output | 1 | 0 = primary selected, 1 = secondary selected |
| clk_bad | output | 2 | Per-input loss flag, high = stopped |
| mux_en | output | 2 | One-hot glitch-free mux enable, all zero during a switch |

## Verification
The assertions assume that op_mode, sw_delay and loss_limit stay fixed while a switch is in progress. They also assume that each reference clock, when running, is slow enough for the two-flop synchronizer to see every level, which means at least two system cycles per level. The stimulus generates each reference from the system clock with a period of six system cycles, offset from the sampling edge. It changes configuration only while the controller is idle, and it stops or restarts a reference only by gating that generator.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
   typedef enum logic [1:0] {
      MODE_AUTO     = 2'd0,
      MODE_MANUAL   = 2'd1,
      MODE_OVERRIDE = 2'd2,
      MODE_AUTO_ALT = 2'd3
   } sw_mode_e;

   typedef enum logic {
      ST_RUN     = 1'b0,
      ST_HOLDOFF = 1'b1
   } sw_state_e;
endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rcs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/rcs_loss_mon.sv
module rcs_loss_mon #(
   parameter int TMO_W      = 8,
   parameter int MIN_TMO    = 8,
   parameter int GOOD_EDGES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl,
   input  logic [TMO_W-1:0] limit,
   output logic             bad
);
   localparam int GE_W = $clog2(GOOD_EDGES + 1);
   localparam logic [TMO_W-1:0] MIN_L   = TMO_W'(MIN_TMO);
   localparam logic [GE_W-1:0]  GE_LAST = GE_W'(GOOD_EDGES - 1);

   generate
      if (MIN_TMO < 2 || MIN_TMO >= (1 << TMO_W)) begin : g_bad_min
         $error("rcs_loss_mon: MIN_TMO out of range for TMO_W");
      end
      if (GOOD_EDGES < 1) begin : g_bad_ge
         $error("rcs_loss_mon: GOOD_EDGES must be positive");
      end
   endgenerate

   logic             lvl_q;
   logic             rise;
   logic [TMO_W-1:0] eff_limit;
   logic [TMO_W-1:0] gap;
   logic [GE_W-1:0]  good_cnt;
   logic             tmo_hit;

   assign rise      = lvl & ~lvl_q;
   assign eff_limit = (limit < MIN_L) ? MIN_L : limit;
   assign tmo_hit   = ({1'b0, gap} + 1'b1) >= {1'b0, eff_limit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q    <= 1'b0;
         gap      <= '0;
         good_cnt <= '0;
         bad      <= 1'b0;
      end else begin
         lvl_q <= lvl;
         if (rise) begin
            gap <= '0;
            if (bad) begin
               if (good_cnt == GE_LAST) begin
                  bad      <= 1'b0;
                  good_cnt <= '0;
               end else begin
                  good_cnt <= good_cnt + 1'b1;
               end
            end
         end else begin
            if (gap != '1) gap <= gap + 1'b1;
            if (tmo_hit) begin
               bad      <= 1'b1;
               good_cnt <= '0;
            end
         end
      end
   end

   AST_EDGE_KEEPS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !$rose(bad)); // R2
   AST_CLEAR_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bad) |-> $past(rise)); // R3
endmodule

// File: rtl/rcs_sw_fsm.sv
module rcs_sw_fsm
   import rcs_pkg::*;
#(
   parameter int DLY_W    = 3,
   parameter int HOLD_CYC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  sw_mode_e         mode,
   input  logic             req_s,
   input  logic [1:0]       bad,
   input  logic [DLY_W-1:0] dly,
   output logic             sel,
   output logic [1:0]       en
);
   localparam int HW = $clog2(HOLD_CYC + 1);
   localparam logic [HW-1:0] HOLD_L    = HW'(HOLD_CYC);
   localparam logic [HW-1:0] HOLD_FIRE = HW'(HOLD_CYC - 1);

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("rcs_sw_fsm: HOLD_CYC must be positive");
      end
      if (DLY_W < 1) begin : g_bad_dly
         $error("rcs_sw_fsm: DLY_W must be positive");
      end
   endgenerate

   sw_state_e        st;
   logic [DLY_W-1:0] cnt;
   logic [HW-1:0]    hold;
   logic             man_ok, auto_ok;
   logic             man_fire, auto_fire, trig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           hold <= '0;
      else if (!req_s)      hold <= '0;
      else if (hold != HOLD_L) hold <= hold + 1'b1;
   end

   always_comb begin
      man_ok  = (mode == MODE_MANUAL) || (mode == MODE_OVERRIDE);
      auto_ok = (mode == MODE_AUTO) || (mode == MODE_AUTO_ALT) ||
                ((mode == MODE_OVERRIDE) && !req_s);
      man_fire  = man_ok && req_s && (hold == HOLD_FIRE);
      auto_fire = auto_ok && bad[sel] && !bad[~sel];
      trig      = man_fire || auto_fire;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_RUN;
         cnt <= '0;
         sel <= 1'b0;
      end else begin
         case (st)
            ST_RUN: begin
               if (trig) begin
                  st  <= ST_HOLDOFF;
                  cnt <= dly;
               end
            end
            default: begin
               if (cnt == '0) begin
                  sel <= ~sel;
                  st  <= ST_RUN;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
         endcase
      end
   end

   assign en = (st != ST_RUN) ? 2'b00 : (sel ? 2'b10 : 2'b01);

   AST_SEL_AFTER_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sel) |-> ($past(st) == ST_HOLDOFF)); // R9
   AST_MANUAL_IGNORES_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && mode == MODE_MANUAL && !req_s) |=> (st == ST_RUN)); // R7
   AST_OVERRIDE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && mode == MODE_OVERRIDE && req_s && hold == HOLD_L) |=> (st == ST_RUN)); // R8
   AST_NO_MOVE_TO_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && !req_s && bad[~sel]) |=> (st == ST_RUN)); // R5
endmodule

// File: rtl/refclk_switch_ctrl.sv
module refclk_switch_ctrl
   import rcs_pkg::*;
#(
   parameter int TMO_W       = 8,
   parameter int DLY_W       = 3,
   parameter int MIN_TMO     = 8,
   parameter int GOOD_EDGES  = 4,
   parameter int HOLD_CYC    = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_sys,
   input  logic             rst_n,
   input  logic [1:0]       op_mode,
   input  logic             sw_req,
   input  logic [DLY_W-1:0] sw_delay,
   input  logic [TMO_W-1:0] loss_limit,
   input  logic             ref_clk0,
   input  logic             ref_clk1,
   output logic             active_sel,
   output logic [1:0]       clk_bad,
   output logic [1:0]       mux_en
);
   localparam int N_REF  = 2;
   localparam int SYNC_W = N_REF + 1;

   logic [SYNC_W-1:0] raw_in, sync_out;

   assign raw_in = {sw_req, ref_clk1, ref_clk0};

   rcs_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk_sys), .rst_n(rst_n), .d(raw_in), .q(sync_out)
   );

   genvar gi;
   generate
      for (gi = 0; gi < N_REF; gi++) begin : g_mon
         rcs_loss_mon #(.TMO_W(TMO_W), .MIN_TMO(MIN_TMO), .GOOD_EDGES(GOOD_EDGES)) u_mon (
            .clk(clk_sys), .rst_n(rst_n), .lvl(sync_out[gi]),
            .limit(loss_limit), .bad(clk_bad[gi])
         );
      end
   endgenerate

   rcs_sw_fsm #(.DLY_W(DLY_W), .HOLD_CYC(HOLD_CYC)) u_fsm (
      .clk(clk_sys), .rst_n(rst_n), .mode(sw_mode_e'(op_mode)),
      .req_s(sync_out[N_REF]), .bad(clk_bad), .dly(sw_delay),
      .sel(active_sel), .en(mux_en)
   );

   AST_EN_ONEHOT: assert property (@(posedge clk_sys) disable iff (!rst_n)
      $onehot0(mux_en)); // R10
   AST_EN_NO_HANDOVER: assert property (@(posedge clk_sys) disable iff (!rst_n)
      ($past(mux_en) != 2'b00 && mux_en != 2'b00) |-> (mux_en == $past(mux_en))); // R10
   AST_EN_FOLLOWS_SEL: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (mux_en != 2'b00) |-> mux_en[active_sel]); // R10
endmodule

// File: tb/refclk_switch_ctrl_test.sv
`timescale 1ns/1ps
module refclk_switch_ctrl_test;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic       ref0 = 1'b0, ref1 = 1'b0, run0 = 1'b1, run1 = 1'b1;
   logic [1:0] mode = 2'd0;
   logic       sw_req = 1'b0;
   logic [2:0] dly = 3'd0;
   logic [7:0] lim = 8'd20;
   logic       active_sel;
   logic [1:0] clk_bad, mux_en;
   int         checks = 0, errors = 0;
   int         ph0 = 0, ph1 = 1, rise0 = 0;
   bit         done = 1'b0;

   typedef struct {
      string      tag;
      logic       sel;
      logic [1:0] bad;
      logic [1:0] en;
   } exp_t;
   exp_t q[$];

   refclk_switch_ctrl uut (
      .clk_sys(clk), .rst_n(rst_n), .op_mode(mode), .sw_req(sw_req),
      .sw_delay(dly), .loss_limit(lim), .ref_clk0(ref0), .ref_clk1(ref1),
      .active_sel(active_sel), .clk_bad(clk_bad), .mux_en(mux_en)
   );

   always #4 clk = ~clk;

   always begin
      @(posedge clk); #2;
      if (run0) begin
         if (ph0 == 2) begin ph0 = 0; ref0 = ~ref0; if (ref0) rise0++; end
         else ph0++;
      end
      if (run1) begin
         if (ph1 == 2) begin ph1 = 0; ref1 = ~ref1; end
         else ph1++;
      end
   end

   // monitor: pops expected items and compares against the outputs
   always @(negedge clk) begin
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (active_sel !== e.sel || clk_bad !== e.bad || mux_en !== e.en) begin
            errors++;
            $display("FAIL %s: sel=%0b bad=%b en=%b expected sel=%0b bad=%b en=%b",
                     e.tag, active_sel, clk_bad, mux_en, e.sel, e.bad, e.en);
         end
      end
   end

   task automatic expect_out(string tag, logic s, logic [1:0] b, logic [1:0] e);
      q.push_back('{tag, s, b, e});
      @(negedge clk); #1;
   endtask

   task automatic check_int(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(int n);
      @(negedge clk) sw_req = 1'b1;
      cyc(n);
      sw_req = 1'b0;
   endtask

   task automatic measure_gap(output int len);
      int k;
      len = 0;
      @(negedge clk) sw_req = 1'b1;
      k = 0;
      while (mux_en != 2'b00 && k < 40) begin @(negedge clk); k++; end
      while (mux_en == 2'b00 && len < 40) begin @(negedge clk); len++; end
      sw_req = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int len;
      cyc(5);
      rst_n = 1'b1;
      expect_out("R1 reset state", 1'b0, 2'b00, 2'b01);
      cyc(50);
      expect_out("R2 flags low while toggling", 1'b0, 2'b00, 2'b01);
      lim = 8'd3;
      cyc(60);
      expect_out("R2 small limit treated as 8", 1'b0, 2'b00, 2'b01);
      lim = 8'd20;

      // automatic mode: lose primary
      run0 = 1'b0;
      cyc(40);
      expect_out("R4 auto switch on loss", 1'b1, 2'b01, 2'b10);
      // recovery hysteresis
      rise0 = 0; run0 = 1'b1;
      while (rise0 < 3) @(posedge clk);
      cyc(4);
      expect_out("R3 still bad after 3 edges", 1'b1, 2'b01, 2'b10);
      while (rise0 < 4) @(posedge clk);
      cyc(5);
      expect_out("R3 clear after 4 edges", 1'b1, 2'b00, 2'b10);

      // both bad
      run0 = 1'b0; cyc(40);
      expect_out("R5 backup bad no switch", 1'b1, 2'b01, 2'b10);
      run1 = 1'b0; cyc(40);
      expect_out("R5 both bad hold", 1'b1, 2'b11, 2'b10);
      run0 = 1'b1; cyc(40);
      expect_out("R5 moves once backup good", 1'b0, 2'b10, 2'b01);
      run1 = 1'b1; cyc(40);
      expect_out("R2 flags recover", 1'b0, 2'b00, 2'b01);

      // manual mode
      mode = 2'd1;
      run0 = 1'b0; cyc(40);
      expect_out("R7 manual ignores loss", 1'b0, 2'b01, 2'b01);
      run0 = 1'b1; cyc(40);
      pulse(2); cyc(20);
      expect_out("R6 two-cycle request ignored", 1'b0, 2'b00, 2'b01);
      pulse(3); cyc(20);
      expect_out("R6 three-cycle request switches", 1'b1, 2'b00, 2'b10);
      pulse(30); cyc(20);
      expect_out("R6 long request single switch", 1'b0, 2'b00, 2'b01);

      // switch delay
      dly = 3'd5;
      measure_gap(len);
      check_int("R9 gap with delay 5", len, 6);
      cyc(10);
      expect_out("R9 selection after delayed switch", 1'b1, 2'b00, 2'b10);
      dly = 3'd0;
      measure_gap(len);
      check_int("R9 gap with delay 0", len, 1);
      cyc(10);
      expect_out("R9 selection after zero delay", 1'b0, 2'b00, 2'b01);

      // override mode
      mode = 2'd2;
      @(negedge clk) sw_req = 1'b1;
      cyc(20);
      expect_out("R8 override request switches", 1'b1, 2'b00, 2'b10);
      run1 = 1'b0; cyc(40);
      expect_out("R8 held request blocks auto", 1'b1, 2'b10, 2'b10);
      sw_req = 1'b0; cyc(20);
      expect_out("R8 auto resumes on release", 1'b0, 2'b10, 2'b01);
      run1 = 1'b1; cyc(40);
      expect_out("R2 secondary recovers", 1'b0, 2'b00, 2'b01);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule